// File: doc/BRIEF.md
# Stream Width Upsizer (Integer Ratio)

This block joins a narrow byte stream to a wider one whose width is a whole multiple of the narrow width. Each accepted narrow beat is written into the next group of byte lanes of a wide word. Groups are filled from the least significant lanes upward. The wide word is offered downstream as soon as every group holds data, or as soon as the narrow beat that ends a packet has been written. A packet that ends part-way through a word therefore leaves as a short final word. Its keep mask covers only the lanes that were written, its unwritten lanes carry zero data, and its last flag is set.

The ratio is fixed when the design is built, so no runtime divide or modulo is needed. A small phase counter selects the lane group to write. A two-state controller decides when the wide word is presented:

- **FILL**: the word is being assembled, and the narrow side is always ready.
- **HOLD**: a completed word is on the wide side.

The transitions are:

- **FILL → HOLD** (*close*): taken when an accepted beat fills the last group or carries the packet-end flag.
- **HOLD → HOLD** (*wait*): taken while downstream is not ready.
- **HOLD → HOLD** (*emit-and-close*): taken when the word leaves and the beat accepted in the same cycle closes a new word.
- **HOLD → FILL** (*emit*): taken when the word leaves and no closing beat arrives with it.

While in HOLD, the narrow side is ready exactly when downstream is ready. A beat can therefore be taken in the same cycle the wide word leaves, and a full-rate input stream runs with no bubble.

Top module: `stream_widener`

## Requirements
- R1: After synchronous reset, `m_tvalid` is 0 and `s_tready` is 1.
- R2: The first beat accepted into a word lands in the lowest lane group, and later beats fill successively higher groups. With 8-bit input and ratio 4, the beats 0x01, 0x02, 0x03, 0x04 give `m_tdata` = 0x04030201.
- R3: A word with all groups written is emitted with every `m_tkeep` bit set (4'b1111 for 8-bit input and ratio 4). Each group's keep bits are taken from the `s_tkeep` of the beat written into that group.
- R4: When a packet-end beat is accepted before the word is full, the partial word is presented on the next cycle. `m_tkeep` is set only for the written groups (three bytes give 4'b0111), and the unwritten lanes of `m_tdata` are zero.
- R5: `m_tlast` is 1 on exactly the wide beat that contains a packet's final narrow beat, whether that word is full or partial, and is 0 on every other wide beat.
- R6: When downstream is always ready, every narrow beat offered is accepted in the cycle it is offered (`s_tready` never drops), including in the cycle a completed word leaves.
- R7: While `m_tvalid` is 1 and `m_tready` is 0, the next cycle still shows `m_tvalid` = 1 with `m_tdata`, `m_tkeep` and `m_tlast` unchanged.
- R8: `s_tready` is 0 whenever a completed word is presented and `m_tready` is 0.
- R9: After every emitted word, whether full or partial, the next accepted beat starts a new word at the lowest lane group with no lanes left over from before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_tdata | input | IN_BYTES*8 | Narrow input data |
| s_tkeep | input | IN_BYTES | Narrow input byte-valid mask |
| s_tlast | input | 1 | Narrow input packet end |
| s_tvalid | input | 1 | Narrow input valid |
| s_tready | output | 1 | Narrow input ready |
| m_tdata | output | IN_BYTES*8*RATIO | Wide output data |
| m_tkeep | output | IN_BYTES*RATIO | Wide output byte-valid mask |
| m_tlast | output | 1 | Wide output packet end |
| m_tvalid | output | 1 | Wide output valid |
| m_tready | input | 1 | Wide output ready |

## Verification
Directed packets of exactly four beats and of three beats separate a correct full-word close from a correct early close. They pin down the lane order, the keep mask and the zero fill of the unused lanes. A run with downstream always ready and input always valid shows whether a beat is accepted in the cycle a word leaves, which is the no-bubble path. Randomised packet lengths from 1 to 11 beats, with random gaps on both handshakes, mix exact multiples, partial tails and back-to-back packets. This exposes phase counters that fail to restart after a partial word and outputs that move during back-pressure.

// File: rtl/widen_pkg.sv
package widen_pkg;
    typedef enum logic {
        ST_FILL = 1'b0,
        ST_HOLD = 1'b1
    } widen_state_t;
endpackage

// File: rtl/widen_ctrl.sv
module widen_ctrl
    import widen_pkg::*;
#(
    parameter int RATIO = 4,
    localparam int PH_W = (RATIO > 1) ? $clog2(RATIO) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            s_tvalid,
    input  logic            s_tlast,
    input  logic            m_tready,
    output logic            s_tready,
    output logic            m_tvalid,
    output logic            m_tlast,
    output logic            wr_en,
    output logic [PH_W-1:0] wr_phase,
    output logic            clr
);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(RATIO - 1);

    widen_state_t    state, state_nx;
    logic [PH_W-1:0] phase, phase_nx;
    logic            emit, closing, last_q;

    assign emit     = (state == ST_HOLD) && m_tready;
    assign wr_en    = s_tvalid && s_tready;
    assign wr_phase = emit ? '0 : phase;
    assign closing  = wr_en && (s_tlast || (wr_phase == LAST_PH));
    assign clr      = emit;
    assign m_tlast  = last_q;

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FILL: if (closing) state_nx = ST_HOLD;
            ST_HOLD: if (emit) state_nx = closing ? ST_HOLD : ST_FILL;
            default: state_nx = ST_FILL;
        endcase
    end

    always_comb begin
        phase_nx = phase;
        if (closing)    phase_nx = '0;
        else if (wr_en) phase_nx = wr_phase + 1'b1;
        else if (emit)  phase_nx = '0;
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_FILL;
            phase  <= '0;
            last_q <= 1'b0;
        end else begin
            state <= state_nx;
            phase <= phase_nx;
            if (closing)   last_q <= s_tlast;
            else if (emit) last_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        s_tready = 1'b1;
        m_tvalid = 1'b0;
        unique case (state)
            ST_FILL: begin
                s_tready = 1'b1;
                m_tvalid = 1'b0;
            end
            ST_HOLD: begin
                s_tready = m_tready;
                m_tvalid = 1'b1;
            end
            default: begin
                s_tready = 1'b1;
                m_tvalid = 1'b0;
            end
        endcase
    end

    // R9
    hold_phase_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD) |-> (phase == '0));

    // R2
    phase_range_chk: assert property (@(posedge clk) disable iff (rst)
        phase <= LAST_PH);

    // R8
    ready_block_chk: assert property (@(posedge clk) disable iff (rst)
        !s_tready |-> (m_tvalid && !m_tready));
endmodule

// File: rtl/widen_lanes.sv
module widen_lanes #(
    parameter int IN_BYTES = 1,
    parameter int RATIO    = 4,
    localparam int IN_W    = IN_BYTES * 8,
    localparam int PH_W    = (RATIO > 1) ? $clog2(RATIO) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      clr,
    input  logic                      wr_en,
    input  logic [PH_W-1:0]           wr_phase,
    input  logic [IN_W-1:0]           din,
    input  logic [IN_BYTES-1:0]       kin,
    output logic [IN_W*RATIO-1:0]     dout,
    output logic [IN_BYTES*RATIO-1:0] kout
);
    for (genvar g = 0; g < RATIO; g++) begin : g_grp
        logic [IN_W-1:0]     d_q;
        logic [IN_BYTES-1:0] k_q;
        logic                sel;

        assign sel = wr_en && (wr_phase == PH_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                d_q <= '0;
                k_q <= '0;
            end else if (sel) begin
                d_q <= din;
                k_q <= kin;
            end else if (clr) begin
                d_q <= '0;
                k_q <= '0;
            end
        end

        assign dout[g*IN_W +: IN_W]         = d_q;
        assign kout[g*IN_BYTES +: IN_BYTES] = k_q;
    end

    // R9
    clear_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !wr_en) |=> (kout == '0 && dout == '0));
endmodule

// File: rtl/stream_widener.sv
module stream_widener #(
    parameter int IN_BYTES = 1,
    parameter int RATIO    = 4,
    localparam int IN_W    = IN_BYTES * 8,
    localparam int OUT_W   = IN_W * RATIO,
    localparam int OUT_B   = IN_BYTES * RATIO,
    localparam int PH_W    = (RATIO > 1) ? $clog2(RATIO) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IN_W-1:0]  s_tdata,
    input  logic [IN_BYTES-1:0] s_tkeep,
    input  logic             s_tlast,
    input  logic             s_tvalid,
    output logic             s_tready,
    output logic [OUT_W-1:0] m_tdata,
    output logic [OUT_B-1:0] m_tkeep,
    output logic             m_tlast,
    output logic             m_tvalid,
    input  logic             m_tready
);
    logic            wr_en, clr;
    logic [PH_W-1:0] wr_phase;

    widen_ctrl #(.RATIO(RATIO)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .s_tvalid (s_tvalid),
        .s_tlast  (s_tlast),
        .m_tready (m_tready),
        .s_tready (s_tready),
        .m_tvalid (m_tvalid),
        .m_tlast  (m_tlast),
        .wr_en    (wr_en),
        .wr_phase (wr_phase),
        .clr      (clr)
    );

    widen_lanes #(.IN_BYTES(IN_BYTES), .RATIO(RATIO)) u_lanes (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .wr_en    (wr_en),
        .wr_phase (wr_phase),
        .din      (s_tdata),
        .kin      (s_tkeep),
        .dout     (m_tdata),
        .kout     (m_tkeep)
    );

    // R7
    stall_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata)
                                     && $stable(m_tkeep) && $stable(m_tlast)));

    // R4
    drain_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && m_tready && !s_tvalid) |=> !m_tvalid);
endmodule

// File: tb/sim_stream_widener.sv
`timescale 1ns/1ps
module sim_stream_widener;
    localparam int IB = 1;
    localparam int RT = 4;
    localparam int IW = IB * 8;
    localparam int OW = IW * RT;
    localparam int OB = IB * RT;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [IW-1:0] s_tdata = '0;
    logic [IB-1:0] s_tkeep = '1;
    logic          s_tlast = 1'b0;
    logic          s_tvalid = 1'b0;
    logic          s_tready;
    logic [OW-1:0] m_tdata;
    logic [OB-1:0] m_tkeep;
    logic          m_tlast;
    logic          m_tvalid;
    logic          m_tready = 1'b0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [IW-1:0] in_d[$];
    bit            in_l[$];
    logic [OW-1:0] ex_d[$];
    logic [OB-1:0] ex_k[$];
    bit            ex_l[$];

    always #4 clk = ~clk;

    stream_widener #(.IN_BYTES(IB), .RATIO(RT)) u0 (
        .clk(clk), .rst(rst),
        .s_tdata(s_tdata), .s_tkeep(s_tkeep), .s_tlast(s_tlast),
        .s_tvalid(s_tvalid), .s_tready(s_tready),
        .m_tdata(m_tdata), .m_tkeep(m_tkeep), .m_tlast(m_tlast),
        .m_tvalid(m_tvalid), .m_tready(m_tready)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [OB-1:0] grp_mask(int filled);
        logic [OB-1:0] m = '0;
        for (int i = 0; i < filled * IB; i++) m[i] = 1'b1;
        return m;
    endfunction

    // builds narrow beats and the expected wide beats of one packet
    task automatic add_pkt(int len, bit seq, int base);
        logic [OW-1:0] w = '0;
        int            n = 0;
        for (int i = 0; i < len; i++) begin
            logic [IW-1:0] v;
            v = seq ? IW'(base + i) : IW'($urandom);
            in_d.push_back(v);
            in_l.push_back(i == len - 1);
            w[n*IW +: IW] = v;
            n++;
            if (n == RT || i == len - 1) begin
                ex_d.push_back(w);
                ex_k.push_back(grp_mask(n));
                ex_l.push_back(i == len - 1);
                w = '0;
                n = 0;
            end
        end
    endtask

    task automatic run(int vpct, int rpct, output int refused);
        bit            stalled = 0;
        logic [OW-1:0] sd;
        logic [OB-1:0] sk;
        logic          sl;
        refused = 0;
        while (in_d.size() > 0 || ex_d.size() > 0) begin
            @(negedge clk);
            s_tvalid = (in_d.size() > 0) && (($urandom % 100) < vpct);
            s_tdata  = (in_d.size() > 0) ? in_d[0] : '0;
            s_tlast  = (in_d.size() > 0) ? in_l[0] : 1'b0;
            m_tready = (($urandom % 100) < rpct);
            #1;
            if (stalled) begin
                chk("R7 valid held", 64'(m_tvalid), 64'd1);
                chk("R7 data held", 64'(m_tdata), 64'(sd));
                chk("R7 keep held", 64'(m_tkeep), 64'(sk));
                chk("R7 last held", 64'(m_tlast), 64'(sl));
            end
            stalled = m_tvalid && !m_tready;
            if (stalled) begin
                sd = m_tdata; sk = m_tkeep; sl = m_tlast;
                chk("R8 ready low", 64'(s_tready), 64'd0);
            end
            if (m_tvalid && m_tready) begin
                if (ex_d.size() == 0) begin
                    chk("R5 unexpected beat", 64'd1, 64'd0);
                end else begin
                    chk("R2 R9 data", 64'(m_tdata), 64'(ex_d[0]));
                    chk((ex_k[0] == '1) ? "R3 keep" : "R4 keep",
                        64'(m_tkeep), 64'(ex_k[0]));
                    chk("R5 last", 64'(m_tlast), 64'(ex_l[0]));
                    void'(ex_d.pop_front());
                    void'(ex_k.pop_front());
                    void'(ex_l.pop_front());
                end
            end
            if (s_tvalid && !s_tready) refused++;
            if (s_tvalid && s_tready) begin
                void'(in_d.pop_front());
                void'(in_l.pop_front());
            end
        end
        @(negedge clk);
        s_tvalid = 1'b0;
        m_tready = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<=100000", cycles);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        int refused;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1
        chk("R1 m_tvalid", 64'(m_tvalid), 64'd0);
        chk("R1 s_tready", 64'(s_tready), 64'd1);

        // R2 R3 R5: full word 01..04
        add_pkt(4, 1, 1);
        run(100, 100, refused);
        // R4 R9: partial word then a new packet at lane 0
        add_pkt(3, 1, 1);
        add_pkt(2, 1, 5);
        run(100, 100, refused);
        // R4 explicit: 3-byte packet presented on the next cycle
        @(negedge clk);
        s_tvalid = 1'b1; m_tready = 1'b0;
        for (int i = 0; i < 3; i++) begin
            s_tdata = IW'(8'h11 * (i + 1));
            s_tlast = (i == 2);
            @(negedge clk);
        end
        s_tvalid = 1'b0;
        #1;
        chk("R4 valid", 64'(m_tvalid), 64'd1);
        chk("R4 data", 64'(m_tdata), 64'h00332211);
        chk("R4 keep", 64'(m_tkeep), 64'b0111);
        chk("R5 last partial", 64'(m_tlast), 64'd1);
        chk("R8 ready while blocked", 64'(s_tready), 64'd0);
        @(negedge clk);
        m_tready = 1'b1;
        @(negedge clk);
        m_tready = 1'b0;
        #1;
        chk("R9 empty after emit", 64'(m_tvalid), 64'd0);

        // R6: full rate, no refusals
        add_pkt(8, 1, 32);
        add_pkt(5, 1, 64);
        run(100, 100, refused);
        chk("R6 no bubble", 64'(refused), 64'd0);

        // random packets with gaps on both sides
        for (int p = 0; p < 60; p++) add_pkt(1 + ($urandom % 11), 0, 0);
        run(70, 60, refused);

        repeat (4) @(negedge clk);
        #1;
        chk("R5 idle after drain", 64'(m_tvalid), 64'd0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule